// File: doc/BRIEF.md
# Three-slot receive mailbox FIFO controller

This block sits behind a frame acceptance filter and queues up to three received messages. Each accepted message arrives on a store strobe with a payload of parameterised width. Software always sees the oldest queued message in an output mailbox. Software discards that message by setting a release bit, which hardware clears again once the pop is done.

A byte-wide register port gives access to two registers. The status register holds the release bit, the sticky overrun and full flags, and the pending-message count. The enable register holds four interrupt enables. The block drives two interrupt lines. The receive line carries the latched first-message event and the transmit-empty request, which comes in from outside. The error line carries the full and overrun flags.

The fill level is held by a four-state machine. The states are S_EMPTY, S_ONE, S_TWO and S_FULL, and each cycle takes one of four transitions:
- PUSH: a message is stored and no release happens. The machine moves one state toward S_FULL.
- POP: a release happens and no message is stored. The machine moves one state toward S_EMPTY.
- BOTH: a store and a release happen in the same cycle. The state is kept.
- IDLE: nothing happens. The state is kept.

A store that arrives in S_FULL with no release in the same cycle is a DROP. A DROP keeps the state. A release requested in S_EMPTY is not a POP.

Top module: `rxq_top`

## Requirements
- R1: After reset the status register reads 00h, the enable register reads 00h, both interrupt lines are low and `mbox_valid` is low.
- R2: Status register (reg_sel=0) layout: bit 5 is the release bit, bit 4 is overrun, bit 3 is full, and bits 1:0 are the pending count. Bits 7:6 and bit 2 read as 0. The count rises by one on each stored message and falls by one on each release, and it does not change otherwise.
- R3: Writing 1 to status bit 5 makes that bit read 1 in the following cycle. In the cycle after that, hardware pops the oldest message and bit 5 reads 0 again. The mailbox then shows the next message.
- R4: A release requested while the count is 0 changes nothing. The count stays 0 and `mbox_valid` stays low.
- R5: The full flag sets when a store brings the count to three. Writing 1 to status bit 3 clears it, and so does a release.
- R6: A store while three messages are held and no release is being done sets the overrun flag. The message is discarded, and the three held messages and their order are kept. Writing 1 to status bit 4 clears overrun. Writing 0 to any status flag bit leaves it unchanged.
- R7: A store and a release in the same cycle are both carried out. The count is unchanged and the mailbox advances to the next message. This holds with three held as well: in that case the full flag is set again and overrun is not.
- R8: Enable register (reg_sel=1) layout: bit 3 enables overrun, bit 2 enables full, bit 1 enables message pending, and bit 0 enables transmit empty. Bits 7:4 read as 0.
- R9: A pending latch sets only when the count goes from 0 to 1, and it is cleared by writing 1 to status bit 0. `irq_rx` is high while the latch is set and enable bit 1 is set. A step from 1 to 2 does not set the latch.
- R10: `irq_err` = (overrun AND enable bit 3) OR (full AND enable bit 2).
- R11: `tx_empty_req` AND enable bit 0 also drives `irq_rx`.
- R12: Messages leave the mailbox in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store strobe for an accepted message |
| st_data | input | DATA_W | Payload of the message being stored |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| mbox_data | output | DATA_W | Payload of the oldest held message |
| mbox_valid | output | 1 | High while at least one message is held |
| tx_empty_req | input | 1 | Transmit-empty interrupt request from outside |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Full/overrun interrupt |

## Verification
The hardest case to reach from the ports is the BOTH transition. The release bit is written in one cycle but takes effect one cycle later, so the store strobe has to be placed in the cycle after the register write. The bench does this in a dedicated task. It runs BOTH at a fill of two and at a fill of three, and then drains the queue to confirm the order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int SLOTS = 3;
    localparam int CNT_W = 2;
    localparam int PTR_W = $clog2(SLOTS);
    localparam int REG_W = 8;

    // status register bit positions
    localparam int B_REL  = 5;
    localparam int B_OVR  = 4;
    localparam int B_FULL = 3;
    localparam int B_PEND = 0;

    // enable register bit positions
    localparam int E_OVR  = 3;
    localparam int E_FULL = 2;
    localparam int E_PEND = 1;
    localparam int E_TX   = 0;
    localparam logic [REG_W-1:0] EN_MASK = 8'h0F;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_ONE   = 2'd1,
        S_TWO   = 2'd2,
        S_FULL  = 2'd3
    } fill_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= step(wr_ptr_q);
            if (pop)  rd_ptr_q <= step(rd_ptr_q);
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (push && (wr_ptr_q == PTR_W'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_ptr_q == PTR_W'(i)) rdata = slot_q[i];
        end
    end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_req,
    input  logic             rel_req,
    output logic             push,
    output logic             pop,
    output logic             drop,
    output logic             first_evt,
    output logic             fill_evt,
    output logic [CNT_W-1:0] cnt
);
    fill_e state_q, state_d;

    // event decode: which of PUSH, POP, BOTH, IDLE, DROP applies this cycle
    always_comb begin
        pop  = rel_req && (state_q != S_EMPTY);
        push = store_req && ((state_q != S_FULL) || pop);
        drop = store_req && (state_q == S_FULL) && !pop;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (push) state_d = S_ONE;
            end
            S_ONE: begin
                if (push && !pop)      state_d = S_TWO;
                else if (pop && !push) state_d = S_EMPTY;
            end
            S_TWO: begin
                if (push && !pop)      state_d = S_FULL;
                else if (pop && !push) state_d = S_ONE;
            end
            S_FULL: begin
                if (pop && !push) state_d = S_TWO;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_EMPTY: cnt = CNT_W'(0);
            S_ONE:   cnt = CNT_W'(1);
            S_TWO:   cnt = CNT_W'(2);
            S_FULL:  cnt = CNT_W'(3);
            default: cnt = CNT_W'(0);
        endcase
        first_evt = (state_q == S_EMPTY) && (state_d == S_ONE);
        fill_evt  = push && (state_d == S_FULL);
    end
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pop,
    input  logic             drop,
    input  logic             first_evt,
    input  logic             fill_evt,
    input  logic             tx_empty_req,
    output logic             rel_req,
    output logic             ovr_flag,
    output logic             full_flag,
    output logic             pend_flag,
    output logic [REG_W-1:0] en_bits,
    output logic             irq_rx,
    output logic             irq_err
);
    logic st_wr;
    logic en_wr;

    assign st_wr = reg_wr && !reg_sel;
    assign en_wr = reg_wr && reg_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_req   <= 1'b0;
            ovr_flag  <= 1'b0;
            full_flag <= 1'b0;
            pend_flag <= 1'b0;
            en_bits   <= '0;
        end else begin
            // release bit lives one cycle; the pop is taken while it is high
            rel_req <= st_wr && reg_wdata[B_REL];

            if (drop)                              ovr_flag <= 1'b1;
            else if (st_wr && reg_wdata[B_OVR])    ovr_flag <= 1'b0;

            if (fill_evt)                                 full_flag <= 1'b1;
            else if (pop || (st_wr && reg_wdata[B_FULL])) full_flag <= 1'b0;

            if (first_evt)                         pend_flag <= 1'b1;
            else if (st_wr && reg_wdata[B_PEND])   pend_flag <= 1'b0;

            if (en_wr) en_bits <= reg_wdata & EN_MASK;
        end
    end

    always_comb begin
        if (reg_sel) reg_rdata = en_bits;
        else         reg_rdata = {2'b00, rel_req, ovr_flag, full_flag, 1'b0, cnt};
    end

    assign irq_rx  = (pend_flag && en_bits[E_PEND]) || (tx_empty_req && en_bits[E_TX]);
    assign irq_err = (ovr_flag && en_bits[E_OVR]) || (full_flag && en_bits[E_FULL]);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_data,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [DATA_W-1:0] mbox_data,
    output logic              mbox_valid,
    input  logic              tx_empty_req,
    output logic              irq_rx,
    output logic              irq_err
);
    logic             push, pop, drop, first_evt, fill_evt;
    logic [CNT_W-1:0] cnt;
    logic             rel_req, ovr_flag, full_flag, pend_flag;
    logic [REG_W-1:0] en_bits;

    rxq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (st_valid),
        .rel_req   (rel_req),
        .push      (push),
        .pop       (pop),
        .drop      (drop),
        .first_evt (first_evt),
        .fill_evt  (fill_evt),
        .cnt       (cnt)
    );

    rxq_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (st_data),
        .rdata (mbox_data)
    );

    rxq_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cnt          (cnt),
        .pop          (pop),
        .drop         (drop),
        .first_evt    (first_evt),
        .fill_evt     (fill_evt),
        .tx_empty_req (tx_empty_req),
        .rel_req      (rel_req),
        .ovr_flag     (ovr_flag),
        .full_flag    (full_flag),
        .pend_flag    (pend_flag),
        .en_bits      (en_bits),
        .irq_rx       (irq_rx),
        .irq_err      (irq_err)
    );

    assign mbox_valid = (cnt != '0);
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       st_valid,
    input logic       rel_wr,
    input logic       push,
    input logic       pop,
    input logic       drop,
    input logic [1:0] cnt,
    input logic       rel_req,
    input logic       ovr_flag,
    input logic       pend_flag,
    input logic       en_ovr,
    input logic       en_full,
    input logic       irq_err
);
    // R2: count holds when neither a store nor a release is taken
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(cnt));

    // R3: the release bit clears itself after one cycle
    a_r3_rel_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !rel_wr) |=> !rel_req);

    // R4: a release with nothing held leaves the queue empty
    a_r4_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && cnt == 2'd0 && !st_valid) |=> (cnt == 2'd0));

    // R6: a discarded store keeps three held and raises overrun
    a_r6_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (cnt == 2'd3 && ovr_flag));

    // R7: store and release together keep the count
    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(cnt));

    // R9: pending latch rises only on a step from zero to one
    a_r9_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_flag) |-> (cnt == 2'd1 && $past(cnt) == 2'd0));

    // R10: error line stays low with both of its enables clear
    a_r10_err_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ovr && !en_full) |-> !irq_err);
endmodule

bind rxq_top rxq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .rel_wr    (reg_wr && !reg_sel && reg_wdata[5]),
    .push      (push),
    .pop       (pop),
    .drop      (drop),
    .cnt       (cnt),
    .rel_req   (rel_req),
    .ovr_flag  (ovr_flag),
    .pend_flag (pend_flag),
    .en_ovr    (en_bits[3]),
    .en_full   (en_bits[2]),
    .irq_err   (irq_err)
);

// File: tb/rxq_top_tb.sv
module rxq_top_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid;
    logic [DW-1:0] st_data;
    logic          reg_sel;
    logic          reg_wr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic [DW-1:0] mbox_data;
    logic          mbox_valid;
    logic          tx_empty_req;
    logic          irq_rx;
    logic          irq_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rxq_top #(.DATA_W(DW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_valid     (st_valid),
        .st_data      (st_data),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .mbox_data    (mbox_data),
        .mbox_valid   (mbox_valid),
        .tx_empty_req (tx_empty_req),
        .irq_rx       (irq_rx),
        .irq_err      (irq_err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input logic sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_mbox(input string tag, input logic vld, input logic [7:0] exp);
        #1;
        check({tag, " valid"}, {7'd0, mbox_valid}, {7'd0, vld});
        if (vld) check({tag, " data"}, mbox_data, exp);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic store(input logic [7:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic release_one();
        wr(1'b0, 8'h20);
        @(negedge clk);
    endtask

    task automatic store_and_release(input logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b0; reg_wdata = 8'h20; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        st_valid = 1'b1; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_reg("R1 status", 1'b0, 8'h00);
        check_reg("R1 enable", 1'b1, 8'h00);
        check("R1 irq", {6'd0, irq_rx, irq_err}, 8'h00);
        check_mbox("R1 mbox", 1'b0, 8'h00);
    endtask

    task automatic t_order();
        store(8'h11);
        store(8'h22);
        check_reg("R2 count two", 1'b0, 8'h02);
        check_mbox("R12 oldest first", 1'b1, 8'h11);
        check("R9 masked", {7'd0, irq_rx}, 8'h00);
        wr(1'b1, 8'h02);
        check("R9 pending irq", {7'd0, irq_rx}, 8'h01);
        wr(1'b0, 8'h20);
        check_reg("R3 release reads one", 1'b0, 8'h22);
        @(negedge clk);
        check_reg("R3 release self-clear", 1'b0, 8'h01);
        check_mbox("R3 next message", 1'b1, 8'h22);
        release_one();
        check_reg("R2 count zero", 1'b0, 8'h00);
        check_mbox("R2 drained", 1'b0, 8'h00);
        check("R9 latch held", {7'd0, irq_rx}, 8'h01);
        wr(1'b0, 8'h01);
        check("R9 latch cleared", {7'd0, irq_rx}, 8'h00);
    endtask

    task automatic t_empty_release();
        release_one();
        check_reg("R4 empty release", 1'b0, 8'h00);
        check_mbox("R4 still empty", 1'b0, 8'h00);
        check("R4 no irq", {7'd0, irq_rx}, 8'h00);
        store(8'h33);
        check_reg("R4 store after", 1'b0, 8'h01);
        check_mbox("R4 mbox", 1'b1, 8'h33);
        check("R9 zero to one", {7'd0, irq_rx}, 8'h01);
        wr(1'b0, 8'h01);
        check("R9 cleared", {7'd0, irq_rx}, 8'h00);
        check_reg("R9 count kept", 1'b0, 8'h01);
        store(8'h34);
        check("R9 one to two no irq", {7'd0, irq_rx}, 8'h00);
        release_one();
        release_one();
        check_reg("R2 drained", 1'b0, 8'h00);
    endtask

    task automatic t_full();
        wr(1'b1, 8'h0C);
        store(8'h41);
        store(8'h42);
        store(8'h43);
        check_reg("R5 full set", 1'b0, 8'h0B);
        check("R10 full irq", {7'd0, irq_err}, 8'h01);
        wr(1'b0, 8'h08);
        check_reg("R5 full w1c", 1'b0, 8'h03);
        check("R10 irq low", {7'd0, irq_err}, 8'h00);
        store(8'h44);
        check_reg("R6 overrun set", 1'b0, 8'h13);
        check("R10 ovr irq", {7'd0, irq_err}, 8'h01);
        check_mbox("R6 kept oldest", 1'b1, 8'h41);
        wr(1'b0, 8'h00);
        check_reg("R6 write zero", 1'b0, 8'h13);
        wr(1'b0, 8'h10);
        check_reg("R6 ovr w1c", 1'b0, 8'h03);
        release_one();
        check_reg("R6 after release", 1'b0, 8'h02);
        check_mbox("R6 second kept", 1'b1, 8'h42);
        store(8'h45);
        check_reg("R5 full again", 1'b0, 8'h0B);
        release_one();
        check_reg("R5 cleared by release", 1'b0, 8'h02);
        check_mbox("R6 third kept", 1'b1, 8'h43);
    endtask

    task automatic t_both();
        store_and_release(8'h46);
        check_reg("R7 count kept", 1'b0, 8'h02);
        check_mbox("R7 advanced", 1'b1, 8'h45);
        store(8'h47);
        check_reg("R7 fill three", 1'b0, 8'h0B);
        store_and_release(8'h48);
        check_reg("R7 both at three", 1'b0, 8'h0B);
        check_mbox("R7 advanced at three", 1'b1, 8'h46);
        release_one();
        check_mbox("R12 order a", 1'b1, 8'h47);
        release_one();
        check_mbox("R12 order b", 1'b1, 8'h48);
        release_one();
        check_reg("R12 drained", 1'b0, 8'h00);
    endtask

    task automatic t_enable();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hFF);
        check_reg("R8 enable layout", 1'b1, 8'h0F);
        tx_empty_req = 1'b1;
        #1;
        check("R11 tx irq", {7'd0, irq_rx}, 8'h01);
        check("R10 no flags", {7'd0, irq_err}, 8'h00);
        wr(1'b1, 8'h00);
        check("R11 tx masked", {7'd0, irq_rx}, 8'h00);
        check_reg("R8 cleared", 1'b1, 8'h00);
        tx_empty_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; st_valid = 1'b0; st_data = '0;
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; tx_empty_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_release();
        t_full();
        t_both();
        t_enable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule